// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

This block is a 32-pin general-purpose I/O bank. Software reaches it through a simple register bus with separate read and write strobes, a 4-bit word address, 32-bit write data and registered read data. Each pin has its own direction bit and its own output level. The input levels pass through a synchronizer before they can be read or used for detection.

Each pin can raise an event on any mix of four conditions: low level, high level, rising edge and falling edge. Events latch into a status register, and software clears bits in that register by writing ones to them. A separate enable mask controls the interrupt. Software can write the mask directly, or use two alias addresses that set or clear selected bits.

A single level-sensitive interrupt line is high whenever a status bit is set and its enable bit is also set. Level conditions keep setting their status bit for as long as they hold. Edge events fire once for each edge.

Top module: `gpiob_top`

## Requirements
- R1: After reset, every pin is an input, so `pin_oe` is 0 and the direction register reads all ones. The output level, the four detect registers, the enable mask and the status register all read 0, and `irq` is low.
- R2: Direction register at address 0: a 1 makes the pin an input and a 0 makes it an output. `pin_oe` is the inverse of this register.
- R3: Output data register at address 1: a write sets `pin_out` from the next clock edge onwards. Reading the register returns the value written.
- R4: Input data register at address 2, read-only: it returns `pin_in` as sampled through a two-stage synchronizer.
- R5: Low-level detect at address 3 and high-level detect at address 4. While a pin's enabled level condition holds, its status bit is set again on every cycle, so a clear that arrives while the condition holds leaves the bit set.
- R6: Rising-edge detect at address 5 and falling-edge detect at address 6. These compare the current synchronized sample with the previous one. A status bit cleared after an edge stays clear until another edge of the selected kind occurs.
- R7: Status register at address 7: writing a 1 to a bit clears it, and writing a 0 leaves it unchanged.
- R8: When a new event and a clear write hit the same status bit in the same cycle, the bit stays set.
- R9: Status bits latch events even when the pin's enable bit is 0.
- R10: Enable mask at address 8, readable and writable. Writing ones to address 9 ORs those bits into the mask, and writing ones to address 10 removes them. Reads at address 9 and address 10 return the mask.
- R11: `irq` is high exactly when the bitwise AND of status and enable is nonzero.
- R12: `bus_rdata` is loaded on the clock edge that samples `bus_rd`. Unmapped addresses (11 to 15) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| pin_in | input | 32 | Pin levels coming from the pads |
| pin_out | output | 32 | Levels driven onto the pins |
| pin_oe | output | 32 | Per-pin output enable (1 = drive) |
| irq | output | 1 | Level-sensitive interrupt request |

## Verification
A stuck or mis-cleared status bit appears on `irq` in the same cycle the status flop updates, provided its enable bit is set. It also appears in the next status read. A wrong edge history shows up about three clock edges after a pin change: an edge event goes missing, or an event fires twice, which reads back as a status bit that does not stay cleared. An error in the enable mask shows within one cycle of the alias write, either as a wrong `irq` or as a wrong value on the next read of any of the three enable addresses.

// File: rtl/gpiob_pkg.sv
package gpiob_pkg;
    localparam int PINS    = 32;
    localparam int ADDR_W  = 4;

    typedef logic [PINS-1:0] pinvec_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIR   = 4'd0,
        REG_DOUT  = 4'd1,
        REG_DIN   = 4'd2,
        REG_DLO   = 4'd3,
        REG_DHI   = 4'd4,
        REG_RISE  = 4'd5,
        REG_FALL  = 4'd6,
        REG_STAT  = 4'd7,
        REG_EN    = 4'd8,
        REG_ENSET = 4'd9,
        REG_ENCLR = 4'd10
    } reg_sel_e;

    typedef struct packed {
        pinvec_t lo;
        pinvec_t hi;
        pinvec_t rise;
        pinvec_t fall;
    } det_cfg_t;

    function automatic pinvec_t mask_update(pinvec_t cur, pinvec_t bits, logic do_set, logic do_clr);
        pinvec_t r;
        r = cur;
        if (do_set) r = r | bits;
        if (do_clr) r = r & ~bits;
        return r;
    endfunction
endpackage

// File: rtl/gpiob_sync.sv
module gpiob_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpiob_detect.sv
module gpiob_detect
    import gpiob_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pinvec_t  cur,
    input  det_cfg_t cfg,
    output pinvec_t  evt
);
    pinvec_t prev;
    pinvec_t rise_hit;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= cur;
    end

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        logic lvl_hit, edge_r, edge_f;
        assign lvl_hit     = (cfg.lo[g] & ~cur[g]) | (cfg.hi[g] & cur[g]);
        assign edge_r      = cfg.rise[g] & cur[g] & ~prev[g];
        assign edge_f      = cfg.fall[g] & ~cur[g] & prev[g];
        assign rise_hit[g] = edge_r;
        assign evt[g]      = lvl_hit | edge_r | edge_f;
    end

    // R6
    rise_single_chk: assert property (@(posedge clk) disable iff (rst)
        ((rise_hit & $past(rise_hit)) == '0));
endmodule

// File: rtl/gpiob_status.sv
module gpiob_status
    import gpiob_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pinvec_t evt,
    input  pinvec_t clr_mask,
    output pinvec_t stat_q
);
    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~clr_mask) | evt;
    end

    // R7
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ((clr_mask & ~evt) != '0) |=> ((stat_q & $past(clr_mask & ~evt)) == '0));

    // R8
    evt_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((stat_q & $past(evt)) == $past(evt)));
endmodule

// File: rtl/gpiob_top.sv
module gpiob_top
    import gpiob_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              irq
);
    pinvec_t  dir_q, dout_q, en_q, din_s, evt, stat_q, clr_mask, rd_mux;
    det_cfg_t cfg_q;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input reg_sel_e s);
        return a == s;
    endfunction

    gpiob_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(din_s)
    );

    gpiob_detect u_detect (
        .clk(clk), .rst(rst), .cur(din_s), .cfg(cfg_q), .evt(evt)
    );

    assign clr_mask = (bus_wr && hit(bus_addr, REG_STAT)) ? bus_wdata : '0;

    gpiob_status u_status (
        .clk(clk), .rst(rst), .evt(evt), .clr_mask(clr_mask), .stat_q(stat_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '1;
            dout_q <= '0;
            cfg_q  <= '0;
            en_q   <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                REG_DIR:   dir_q      <= bus_wdata;
                REG_DOUT:  dout_q     <= bus_wdata;
                REG_DLO:   cfg_q.lo   <= bus_wdata;
                REG_DHI:   cfg_q.hi   <= bus_wdata;
                REG_RISE:  cfg_q.rise <= bus_wdata;
                REG_FALL:  cfg_q.fall <= bus_wdata;
                REG_EN:    en_q       <= bus_wdata;
                REG_ENSET: en_q       <= mask_update(en_q, bus_wdata, 1'b1, 1'b0);
                REG_ENCLR: en_q       <= mask_update(en_q, bus_wdata, 1'b0, 1'b1);
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (bus_addr)
            REG_DIR:   rd_mux = dir_q;
            REG_DOUT:  rd_mux = dout_q;
            REG_DIN:   rd_mux = din_s;
            REG_DLO:   rd_mux = cfg_q.lo;
            REG_DHI:   rd_mux = cfg_q.hi;
            REG_RISE:  rd_mux = cfg_q.rise;
            REG_FALL:  rd_mux = cfg_q.fall;
            REG_STAT:  rd_mux = stat_q;
            REG_EN, REG_ENSET, REG_ENCLR: rd_mux = en_q;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assign pin_out = dout_q;
    assign pin_oe  = ~dir_q;
    assign irq     = |(stat_q & en_q);

    // R2
    dir_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_DIR) |=> (pin_oe == ~$past(bus_wdata)));

    // R3
    dout_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_DOUT) |=> (pin_out == $past(bus_wdata)));

    // R10
    en_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_ENSET) |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata)));

    // R10
    en_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_ENCLR) |=> ((en_q & $past(bus_wdata)) == '0));
endmodule

// File: tb/gpiob_top_bench.sv
`timescale 1ns/1ps
module gpiob_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] pin_in = '0, pin_out, pin_oe;
    logic        irq;
    logic        rd_d = 1'b0;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    typedef struct { logic [31:0] exp; string tag; } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    gpiob_top u_gpiob_top (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [3:0] a, logic [31:0] exp, string tag);
        exp_t e;
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        e.exp = exp; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: rdata is loaded on the edge that samples bus_rd
    always @(posedge clk) rd_d <= bus_rd;
    always @(negedge clk) begin
        if (rd_d) begin
            if (sb_q.size() == 0) chk("R12 unexpected read", bus_rdata, 32'hx);
            else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(e.tag, bus_rdata, e.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 pin_oe", pin_oe, 32'h0);
        chk("R1 pin_out", pin_out, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        bus_read(4'd0, 32'hFFFF_FFFF, "R1 dir");
        bus_read(4'd3, 32'h0, "R1 dlo");
        bus_read(4'd7, 32'h0, "R1 stat");
        bus_read(4'd8, 32'h0, "R1 en");

        // R2 direction
        bus_write(4'd0, 32'hFFFF_0000);
        chk("R2 pin_oe", pin_oe, 32'h0000_FFFF);
        bus_read(4'd0, 32'hFFFF_0000, "R2 dir readback");

        // R3 output data
        bus_write(4'd1, 32'hA5A5_0F0F);
        chk("R3 pin_out", pin_out, 32'hA5A5_0F0F);
        bus_read(4'd1, 32'hA5A5_0F0F, "R3 dout readback");

        // R4 input data through synchronizer
        @(negedge clk); pin_in = 32'h1234_5670;
        idle(3);
        bus_read(4'd2, 32'h1234_5670, "R4 din");
        @(negedge clk); pin_in = 32'h0;
        idle(4);
        bus_read(4'd2, 32'h0, "R4 din zero");

        // R6 rising edge, R9 latch while disabled
        bus_write(4'd5, 32'h1);
        @(negedge clk); pin_in[0] = 1'b1;
        idle(4);
        bus_read(4'd7, 32'h1, "R9 rise latched, enable 0");
        chk("R11 irq low while disabled", {31'b0, irq}, 32'h0);
        // R7 write 0 leaves, write 1 clears
        bus_write(4'd7, 32'h0);
        bus_read(4'd7, 32'h1, "R7 write zero keeps");
        bus_write(4'd7, 32'h1);
        idle(3);
        bus_read(4'd7, 32'h0, "R6 edge stays clear");

        // R6 falling edge on pin 1
        bus_write(4'd6, 32'h2);
        @(negedge clk); pin_in[1] = 1'b1;
        idle(4);
        bus_read(4'd7, 32'h0, "R6 no fall on rise");
        @(negedge clk); pin_in[1] = 1'b0;
        idle(4);
        bus_read(4'd7, 32'h2, "R6 fall latched");
        bus_write(4'd7, 32'h2);

        // R5 high level on pin 2
        bus_write(4'd4, 32'h4);
        @(negedge clk); pin_in[2] = 1'b1;
        idle(4);
        bus_read(4'd7, 32'h4, "R5 high level");
        bus_write(4'd7, 32'h4);
        bus_read(4'd7, 32'h4, "R5 level reasserts");
        @(negedge clk); pin_in[2] = 1'b0;
        idle(4);
        bus_write(4'd7, 32'h4);
        bus_read(4'd7, 32'h0, "R5 clears after level drops");

        // R5 low level on pin 3 (pin already low)
        bus_write(4'd3, 32'h8);
        idle(2);
        bus_read(4'd7, 32'h8, "R5 low level");
        @(negedge clk); pin_in[3] = 1'b1;
        idle(4);
        bus_write(4'd7, 32'h8);
        bus_read(4'd7, 32'h0, "R5 low level released");
        bus_write(4'd3, 32'h0);

        // R10 enable aliases
        bus_write(4'd9, 32'h3);
        bus_read(4'd8, 32'h3, "R10 set alias");
        bus_write(4'd10, 32'h1);
        bus_read(4'd8, 32'h2, "R10 clear alias");
        bus_read(4'd9, 32'h2, "R10 read at set alias");
        bus_read(4'd10, 32'h2, "R10 read at clear alias");

        // R11 irq
        @(negedge clk); pin_in[1] = 1'b1;
        idle(4);
        @(negedge clk); pin_in[1] = 1'b0;
        idle(4);
        chk("R11 irq on enabled status", {31'b0, irq}, 32'h1);
        bus_write(4'd10, 32'h2);
        chk("R11 irq off when disabled", {31'b0, irq}, 32'h0);
        bus_read(4'd7, 32'h2, "R9 status kept when disabled");
        bus_write(4'd9, 32'h2);
        chk("R11 irq back on", {31'b0, irq}, 32'h1);
        bus_write(4'd7, 32'h2);
        chk("R11 irq off after clear", {31'b0, irq}, 32'h0);

        // R8 event and clear in the same cycle (pin 0 rising)
        @(negedge clk); pin_in[0] = 1'b0;
        idle(4);
        @(negedge clk); pin_in[0] = 1'b1;
        idle(4);
        @(negedge clk); pin_in[0] = 1'b0;
        idle(4);
        bus_read(4'd7, 32'h1, "R8 precondition");
        @(negedge clk); pin_in[0] = 1'b1;
        @(negedge clk);
        bus_write(4'd7, 32'h1);
        idle(2);
        bus_read(4'd7, 32'h1, "R8 event wins");

        // R12 unmapped
        bus_read(4'd13, 32'h0, "R12 unmapped");

        idle(4);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule